// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one memory write command into a page-sized staging buffer, then copies them into the storage array during a self-timed busy interval. A command opens with a start pulse that carries the first target address. The page is fixed by the upper address bits, and the low bits choose the first column. Each valid byte lands in the current column, and the column pointer then advances, wrapping inside the page. An upstream serial front end raises the commit pulse only when the command ended with a complete byte count. Nothing reaches the array before that pulse.

After a commit the block stays busy for a fixed number of system clock cycles. The first page-sized stretch of that interval is a scan over every column. A column is written to the array only if it received a byte in this command and the protect unit grants permission for its address. Columns that received nothing keep their old contents. When the interval ends, a one-cycle done pulse is given, which a neighbouring block uses to clear its write-enable latch. Start, byte and commit pulses that arrive while busy are dropped.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, busy, wr_done and arr_we are 0.
- R2: A start pulse latches the page (start_addr bits above the column field) and the column (start_addr[COL_W-1:0], COL_W = log2 PAGE_BYTES). Successive bytes go to successive columns, and the array address is {page, column}.
- R3: After the byte for column PAGE_BYTES-1, the next byte goes to column 0 of the same page.
- R4: When more than PAGE_BYTES bytes are sent, each column holds the last byte sent to it.
- R5: Only columns loaded since the latest start pulse are written. Every other array byte keeps its value.
- R6: The array is not written before the commit pulse.
- R7: A commit accepted while idle raises busy in the next cycle, and busy then stays 1 for exactly WRITE_CYCLES cycles (WRITE_CYCLES is raised to PAGE_BYTES if set below it).
- R8: wr_done is a single-cycle pulse, in the first cycle that busy is 0 after the interval.
- R9: A loaded column is written only when arr_allow is 1 for its address in its scan cycle.
- R10: Start, byte and commit pulses are ignored while busy. The busy interval does not restart, and the buffer and the latched page do not change.
- R11: arr_we is 1 only while busy, and only for addresses inside the latched page.
- R12: A start pulse clears all loaded marks, so a commit with no bytes after it writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Opens a write command and latches start_addr |
| start_addr | input | ADDR_W | First byte address of the command |
| byte_valid | input | 1 | byte_data holds a data byte to stage |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | End of a correctly sized command, starts the write cycle |
| arr_allow | input | 1 | Protect unit grant for the address on arr_addr |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array address being scanned |
| arr_wdata | output | 8 | Byte for the array |
| busy | output | 1 | Write cycle in progress |
| wr_done | output | 1 | One-cycle pulse when the write cycle ends |

## Verification
The bench builds the block with ADDR_W = 6, PAGE_BYTES = 8 and WRITE_CYCLES = 20. This gives a 64-byte array of eight pages, which the bench mirrors in full. Column wrap and page overrun can then be reached with a handful of bytes, and busy-length counting stays short. With a small page, the hold stretch after the scan is wider than the scan, so drops during busy are tested both inside and after the scan.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SCAN = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;

endpackage

// File: rtl/pcb_column_store.sv
module pcb_column_store
  import pcb_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             frame_start,
  input  logic [COL_W-1:0] start_col,
  input  logic             byte_valid,
  input  byte_t            byte_data,
  input  logic [COL_W-1:0] scan_idx,
  output byte_t            slot_data,
  output logic             slot_loaded
);

  // pointer step inside the page, wrapping at the last column
  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] c);
    if (c == COL_W'(PAGE_BYTES - 1)) return '0;
    return c + COL_W'(1);
  endfunction

  logic [COL_W-1:0]    ptr_q;
  logic [PAGE_BYTES-1:0] loaded_q;
  byte_t               data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] load_hit;
  logic                open_cmd;
  logic                take_byte;

  assign open_cmd  = accept && frame_start;
  assign take_byte = accept && byte_valid && !frame_start;

  for (genvar c = 0; c < PAGE_BYTES; c++) begin : g_hit
    assign load_hit[c] = take_byte && (ptr_q == COL_W'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (open_cmd) begin
      ptr_q <= start_col;
    end else if (take_byte) begin
      ptr_q <= next_col(ptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
      for (int c = 0; c < PAGE_BYTES; c++) data_q[c] <= '0;
    end else if (open_cmd) begin
      loaded_q <= '0;
    end else begin
      for (int c = 0; c < PAGE_BYTES; c++) begin
        if (load_hit[c]) begin
          loaded_q[c] <= 1'b1;
          data_q[c]   <= byte_data;
        end
      end
    end
  end

  assign slot_data   = data_q[scan_idx];
  assign slot_loaded = loaded_q[scan_idx];

endmodule

// File: rtl/pcb_timer.sv
module pcb_timer
  import pcb_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 100,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  output logic             busy,
  output logic             done,
  output logic             scan_on,
  output logic [COL_W-1:0] scan_idx
);

  function automatic logic is_last(input logic [CNT_W-1:0] n);
    return n == CNT_W'(BUSY_CYCLES - 1);
  endfunction

  function automatic logic scan_end(input logic [CNT_W-1:0] n);
    return n == CNT_W'(PAGE_BYTES - 1);
  endfunction

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (commit) begin
            phase_q <= PH_SCAN;
            cnt_q   <= '0;
          end
        end
        PH_SCAN, PH_HOLD: begin
          if (is_last(cnt_q)) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (phase_q == PH_SCAN && scan_end(cnt_q)) phase_q <= PH_HOLD;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy     = phase_q != PH_IDLE;
  assign scan_on  = phase_q == PH_SCAN;
  assign scan_idx = cnt_q[COL_W-1:0];
  assign done     = done_q;

endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
  import pcb_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 100,
  localparam int COL_W       = $clog2(PAGE_BYTES),
  localparam int PAGE_W      = ADDR_W - COL_W,
  localparam int BUSY_CYCLES = (WRITE_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WRITE_CYCLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              commit,
  input  logic              arr_allow,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              busy,
  output logic              wr_done
);

  // named internal events, also watched by the bound checker
  logic [PAGE_W-1:0] cmd_page;
  logic [COL_W-1:0]  scan_idx;
  logic              scan_on;
  byte_t             slot_data;
  logic              slot_loaded;
  logic              accept;

  assign accept = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cmd_page <= '0;
    else if (accept && frame_start)    cmd_page <= start_addr[ADDR_W-1:COL_W];
  end

  pcb_column_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .frame_start (frame_start),
    .start_col   (start_addr[COL_W-1:0]),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .scan_idx    (scan_idx),
    .slot_data   (slot_data),
    .slot_loaded (slot_loaded)
  );

  pcb_timer #(.PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .busy     (busy),
    .done     (wr_done),
    .scan_on  (scan_on),
    .scan_idx (scan_idx)
  );

  assign arr_addr  = {cmd_page, scan_idx};
  assign arr_wdata = slot_data;
  assign arr_we    = scan_on && slot_loaded && arr_allow;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int ADDR_W      = 14,
  parameter int COL_W       = 6,
  parameter int BUSY_CYCLES = 100
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    commit,
  input logic                    arr_allow,
  input logic                    arr_we,
  input logic [ADDR_W-1:0]       arr_addr,
  input logic                    busy,
  input logic                    wr_done,
  input logic [ADDR_W-COL_W-1:0] cmd_page
);

  // R7: accepted commit raises busy next cycle
  a_r7_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !busy) |=> busy);

  // R6: busy only ever starts from a commit
  a_r6_busy_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  // R8: done is one cycle wide and sits on the falling edge of busy
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  a_r8_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (!busy && $past(busy)));

  // R11: strobes only while busy and only inside the latched page
  a_r11_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  a_r11_we_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_addr[ADDR_W-1:COL_W] == cmd_page));

  // R9: no strobe without protect-unit grant
  a_r9_we_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> arr_allow);

  // R10: latched page frozen while busy
  a_r10_page_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_page));

  // R7: busy length measured with a counter
  int unsigned run_q;
  logic        busy_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 0;
      busy_d <= 1'b0;
    end else begin
      busy_d <= busy;
      if (busy) run_q <= run_q + 1;
      else      run_q <= 0;
      if (busy_d && !busy) begin
        a_r7_busy_len: assert (run_q == BUSY_CYCLES);
      end
    end
  end

endmodule

bind page_commit_buf pcb_checker #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .arr_allow(arr_allow),
  .arr_we(arr_we), .arr_addr(arr_addr), .busy(busy), .wr_done(wr_done),
  .cmd_page(cmd_page)
);

// File: tb/page_commit_buf_test.sv
module page_commit_buf_test;

  localparam int AW   = 6;
  localparam int PG   = 8;
  localparam int WC   = 20;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_data = '0;
  logic          commit = 1'b0;
  logic          arr_allow;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;
  logic          busy;
  logic          wr_done;
  logic [7:0]    lim = 8'd64;

  always #10 clk = ~clk;

  assign arr_allow = ({2'b00, arr_addr} < lim);

  page_commit_buf #(.ADDR_W(AW), .PAGE_BYTES(PG), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .commit(commit),
    .arr_allow(arr_allow), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .busy(busy), .wr_done(wr_done)
  );

  // array mirror fed by the write strobes
  logic [7:0] mem_q [MEMN];
  int         we_count;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem_q[i] <= 8'(i) ^ 8'hA5;
      we_count <= 0;
    end else if (arr_we) begin
      mem_q[arr_addr] <= arr_wdata;
      we_count <= we_count + 1;
    end
  end

  // reference model
  logic [7:0] exp_m [MEMN];
  logic [7:0] lbuf [PG];
  logic       lflag [PG];
  int         lpage;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_cmd(input int addr, input int n, input int seed);
    int col;
    lpage = addr / PG;
    col = addr % PG;
    for (int c = 0; c < PG; c++) lflag[c] = 1'b0;
    for (int i = 0; i < n; i++) begin
      lbuf[col] = 8'(seed + i);
      lflag[col] = 1'b1;
      col = (col + 1) % PG;
    end
  endtask

  task automatic model_commit(input int limit);
    for (int c = 0; c < PG; c++) begin
      int a;
      a = lpage * PG + c;
      if (lflag[c] && a < limit) exp_m[a] = lbuf[c];
    end
  endtask

  task automatic send_bytes(input int addr, input int n, input int seed);
    @(negedge clk);
    frame_start = 1'b1; start_addr = AW'(addr);
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1; byte_data = 8'(seed + i);
      @(negedge clk);
    end
    byte_valid = 1'b0;
  endtask

  // pulse commit, count busy cycles, optionally inject pulses while busy
  task automatic do_commit(input string tag, input logic inject);
    int n;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (inject && n == 3) begin byte_valid = 1'b1; byte_data = 8'hEE; commit = 1'b1; end
      else if (inject && n == 4) begin byte_valid = 1'b0; commit = 1'b0; end
      if (inject && n == WC - 2) begin frame_start = 1'b1; start_addr = AW'(6'h3F); end
      if (inject && n == WC - 1) frame_start = 1'b0;
      @(negedge clk);
    end
    chk(n == WC, {tag, " R7 busy length"}, n, WC);
    chk(wr_done == 1'b1, {tag, " R8 done at busy fall"}, int'(wr_done), 1);
    @(negedge clk);
    chk(wr_done == 1'b0 && busy == 1'b0, {tag, " R8 done single / R10 no restart"},
        int'(wr_done) + 2 * int'(busy), 0);
  endtask

  task automatic cmp_mem(input string tag);
    int bad_at;
    bad_at = -1;
    for (int i = 0; i < MEMN; i++) if (mem_q[i] !== exp_m[i] && bad_at < 0) bad_at = i;
    if (bad_at < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("%s byte @%0d", tag, bad_at), int'(mem_q[bad_at]), int'(exp_m[bad_at]));
  endtask

  // {start_addr, nbytes, seed, protect limit}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'd8,  8'h10, 8'd64},   // R2 full page
    {8'h0B, 8'd3,  8'h20, 8'd64},   // R5 partial, mid page
    {8'h16, 8'd5,  8'h30, 8'd64},   // R3 wrap in page
    {8'h21, 8'd19, 8'h40, 8'd64},   // R4 overrun, last byte wins
    {8'h38, 8'd8,  8'h50, 8'd60},   // R9 top of page protected
    {8'h2D, 8'd1,  8'h60, 8'd0}     // R9 all protected
  };

  initial begin
    for (int i = 0; i < MEMN; i++) exp_m[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && wr_done == 1'b0 && arr_we == 1'b0, "R1 reset outputs",
        int'(busy) + 2 * int'(wr_done) + 4 * int'(arr_we), 0);
    cmp_mem("R1 array untouched");

    for (int v = 0; v < NV; v++) begin
      int a, n, s, l, w0;
      a = int'(VEC[v][31:24]); n = int'(VEC[v][23:16]);
      s = int'(VEC[v][15:8]);  l = int'(VEC[v][7:0]);
      lim = 8'(l);
      w0 = we_count;
      send_bytes(a, n, s);
      chk(we_count == w0, $sformatf("R6 no write before commit v%0d", v), we_count - w0, 0);
      model_cmd(a, n, s);
      model_commit(l);
      do_commit($sformatf("v%0d", v), 1'b0);
      cmp_mem($sformatf("R2 R3 R4 R5 R9 array v%0d", v));
    end

    // R10: pulses during busy are dropped; a bare re-commit rewrites the same bytes
    lim = 8'd64;
    send_bytes(6'h10, 8, 8'h70);
    model_cmd(6'h10, 8, 8'h70);
    model_commit(64);
    do_commit("R10 inject", 1'b1);
    cmp_mem("R10 array after inject");
    do_commit("R10 recommit", 1'b0);
    model_commit(64);
    cmp_mem("R10 buffer unchanged by busy pulses");

    // R12: start pulse clears loaded marks
    begin
      int w0;
      w0 = we_count;
      send_bytes(6'h08, 0, 0);
      do_commit("R12", 1'b0);
      chk(we_count == w0, "R12 empty command writes nothing", we_count - w0, 0);
      cmp_mem("R12 array unchanged");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule